// File: doc/BRIEF.md
# Prioritizing Memory-Mapped Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines (96 by default) and presents one interrupt request to a processor. Software reaches it over a simple 32-bit register bus with a combinational read path and a single-cycle write strobe. Each line has a mask bit, kept in banks of 32, and a 6-bit priority. Among the lines that are active, unmasked and below the priority threshold, the controller picks the one with the numerically smallest priority. Equal priorities go to the lower line number.

Picking a winner is not instant. Once a candidate is seen, the controller runs a fixed sorting window of `SORT_CYC` cycles (10 by default). At the end of the window it latches the result into the active-source register and raises `irq_o`. The result is flagged as spurious if the candidate line dropped during the window, or if a mask write during the window changed the winner. Spurious results are marked by setting bits 31:7 of that register to all ones. `irq_o` stays high, and no new sort begins, until software writes the acknowledge bit.

A soft reset, started from the configuration register, returns every register to its power-on value. A reset-done flag reports when the soft reset has finished. A read-only revision register, plus idle, protection and autoidle bits, are provided as plain storage.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a hardware reset or a soft reset: `irq_o` is 0, the active-source register (0x40) reads 0, every mask bank reads 0xFFFFFFFF (all masked), every level register reads 0, the threshold (0x68) reads 0xFF, and configuration bit 0 reads 0.
- R2: A write with bit 1 set to the configuration register (0x10) performs a soft reset on that clock edge. Bit 0 of the status register (0x14) reads 0 in the following cycle and 1 from the cycle after that. Configuration bit 1 always reads back 0.
- R3: The revision register (0x00) reads the major version in bits 7:4 and the minor version in bits 3:0, taken from parameters. All higher bits read 0.
- R4: Bank b (b = 0 to N_SRC/32 − 1) has three registers. The mask register at 0x84+0x20·b is readable and writable. Writing 1s to 0x88+0x20·b clears the matching mask bits. Writing 1s to 0x8C+0x20·b sets them. Bit j of bank b belongs to line 32·b+j. Bits written as 0 are unchanged.
- R5: The pending register at 0x98+0x20·b reads bit j = 1 exactly when line 32·b+j is active and unmasked.
- R6: The level register for line n is at 0x100+4·n and holds its priority in bits 7:2 (0 is most urgent). The winner is the eligible line with the smallest priority, ties going to the lower line number. A clean result reads as the line number in bits 6:0 of 0x40, with bits 31:7 equal to 0.
- R7: A line whose priority is greater than or equal to the threshold (0x68, bits 7:0) is not eligible, unless the threshold is 0xFF.
- R8: A sort starts on the first clock edge at which the controller is idle and an eligible line exists. `irq_o` rises exactly `SORT_CYC` clock edges after that.
- R9: If the candidate line is inactive or masked at any edge during the window, the result is spurious. In that case 0x40 reads bits 31:7 all ones, and bits 6:0 hold the candidate's number.
- R10: If a mask write occurs during the window and the winner at the end differs from the candidate, the result is spurious. A mask write that leaves the winner unchanged gives a clean result.
- R11: Once raised, `irq_o` and 0x40 hold their values while lines change, until bit 0 is written as 1 to the control register (0x48). `irq_o` is then 0 in the next cycle. No new sort starts before that acknowledge.
- R12: Threshold (0x68, bits 7:0), idle (0x50, bits 1:0), protection (0x4C, bit 0) and autoidle (0x10, bit 0) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Level interrupt lines, active high |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps every line alone through a full sort, so that a wrong line number or an off-by-one latency shows at once. It then checks hashed multi-line patterns against a priority minimum computed in the bench, where a reversed tie-break or a wrong priority field would pick the wrong line. It drops a candidate mid-window, and makes mask writes that do and do not change the winner. A design that ignored either spurious case would report a stale line number, and one that flagged every mask write would mark a clean result as spurious. It also sets the threshold equal to a priority and one above it, swaps lines while the request is held, and fires a soft reset while a request is pending, to catch an off-by-one threshold compare, a re-sort before acknowledge, and a reset-done flag that never drops.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned IDW = 7;
  localparam int unsigned PW = 6;

  localparam logic [AW-1:0] A_REV      = 12'h000;
  localparam logic [AW-1:0] A_CFG      = 12'h010;
  localparam logic [AW-1:0] A_STAT     = 12'h014;
  localparam logic [AW-1:0] A_ACTIVE   = 12'h040;
  localparam logic [AW-1:0] A_CTRL     = 12'h048;
  localparam logic [AW-1:0] A_PROT     = 12'h04C;
  localparam logic [AW-1:0] A_IDLE     = 12'h050;
  localparam logic [AW-1:0] A_THR      = 12'h068;
  localparam logic [AW-1:0] A_MASK0    = 12'h084;
  localparam logic [AW-1:0] A_UNMASK0  = 12'h088;
  localparam logic [AW-1:0] A_SETMASK0 = 12'h08C;
  localparam logic [AW-1:0] A_PEND0    = 12'h098;
  localparam logic [AW-1:0] A_LVL0     = 12'h100;

  // address of a per-bank register (32 bytes between banks)
  function automatic logic [AW-1:0] bank_addr(input logic [AW-1:0] base, input int b);
    return base + AW'(b * 32);
  endfunction

  // address of the level register of one line
  function automatic logic [AW-1:0] lvl_addr(input int n);
    return A_LVL0 + AW'(n * 4);
  endfunction

  // threshold filter; 0xFF turns filtering off
  function automatic logic prio_ok(input logic [PW-1:0] p, input logic [7:0] thr);
    return (thr == 8'hFF) || ({2'b00, p} < thr);
  endfunction

  // format of the active-source word
  function automatic logic [31:0] active_word(input logic spur, input logic [IDW-1:0] id);
    return {{25{spur}}, id};
  endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        full_we,
  input  logic        clr_we,
  input  logic        set_we,
  input  logic [31:0] wdata,
  input  logic [31:0] src,
  output logic [31:0] mask_q,
  output logic [31:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (soft_rst) mask_q <= '1;
    else if (full_we)  mask_q <= wdata;
    else if (clr_we)   mask_q <= mask_q & ~wdata;
    else if (set_we)   mask_q <= mask_q | wdata;
  end

  assign pend = src & ~mask_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned N = 96
) (
  input  logic                     elig [N],
  input  logic [irqc_pkg::PW-1:0]  prio [N],
  output logic                     win_valid,
  output logic [irqc_pkg::IDW-1:0] win_id
);
  import irqc_pkg::*;
  logic [PW:0] best;

  // strict compare keeps the lower index on a tie
  always_comb begin
    best      = {1'b1, {PW{1'b0}}};
    win_valid = 1'b0;
    win_id    = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && ({1'b0, prio[i]} < best)) begin
        best      = {1'b0, prio[i]};
        win_valid = 1'b1;
        win_id    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_sorter.sv
module irqc_sorter #(
  parameter int unsigned N        = 96,
  parameter int unsigned SORT_CYC = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     win_valid,
  input  logic [irqc_pkg::IDW-1:0] win_id,
  input  logic [N-1:0]             pend,
  input  logic                     mask_wr,
  input  logic                     ack,
  output logic                     irq,
  output logic [31:0]              active_q,
  output logic                     sort_start,
  output logic                     sort_done
);
  import irqc_pkg::*;
  localparam int unsigned CW = $clog2(SORT_CYC);
  localparam int unsigned SW = $clog2(N);

  typedef enum logic [1:0] {S_IDLE, S_SORT, S_HOLD} sort_st_t;
  sort_st_t st;
  logic [CW-1:0]  cnt;
  logic [IDW-1:0] cand;
  logic           dropped, mask_seen;
  logic           cand_live, spur_now;

  assign cand_live  = pend[cand[SW-1:0]];
  assign sort_start = (st == S_IDLE) && win_valid;
  assign sort_done  = (st == S_SORT) && (cnt == CW'(SORT_CYC - 1));
  assign spur_now   = dropped || !cand_live ||
                      ((mask_seen || mask_wr) && (!win_valid || win_id != cand));
  assign irq        = (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cand <= '0;
      dropped <= 1'b0; mask_seen <= 1'b0; active_q <= '0;
    end else if (soft_rst) begin
      st <= S_IDLE; cnt <= '0; cand <= '0;
      dropped <= 1'b0; mask_seen <= 1'b0; active_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (win_valid) begin
          st <= S_SORT; cnt <= '0; cand <= win_id;
          dropped <= 1'b0; mask_seen <= 1'b0;
        end
        S_SORT: begin
          cnt <= cnt + 1'b1;
          if (!cand_live) dropped <= 1'b1;
          if (mask_wr) mask_seen <= 1'b1;
          if (sort_done) begin
            st       <= S_HOLD;
            active_q <= active_word(spur_now, cand);
          end
        end
        S_HOLD: if (ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_SRC     = 96,
  parameter int unsigned SORT_CYC  = 10,
  parameter logic [3:0]  REV_MAJOR = 4'd5,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o
);
  import irqc_pkg::*;
  localparam int unsigned NB = N_SRC / 32;

  logic             soft_rst, ack_fire, rst_done_q;
  logic             autoidle_q, prot_q;
  logic [1:0]       idle_q;
  logic [7:0]       thr_q;
  logic [PW-1:0]    prio_q [N_SRC];
  logic             elig   [N_SRC];
  logic [N_SRC-1:0] mask_all, pend_all;
  logic [NB-1:0]    bank_wr;
  logic             mask_wr;
  logic             win_valid;
  logic [IDW-1:0]   win_id;
  logic [31:0]      sir_q;
  logic             sort_start, sort_done;

  assign soft_rst = bus_we && (bus_addr == A_CFG) && bus_wdata[1];
  assign ack_fire = bus_we && (bus_addr == A_CTRL) && bus_wdata[0];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic full_we, clr_we, set_we;
    assign full_we = bus_we && (bus_addr == bank_addr(A_MASK0, b));
    assign clr_we  = bus_we && (bus_addr == bank_addr(A_UNMASK0, b));
    assign set_we  = bus_we && (bus_addr == bank_addr(A_SETMASK0, b));
    assign bank_wr[b] = full_we || clr_we || set_we;
    irqc_mask_bank u_bank (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .full_we(full_we), .clr_we(clr_we), .set_we(set_we),
      .wdata(bus_wdata), .src(src_i[b*32 +: 32]),
      .mask_q(mask_all[b*32 +: 32]), .pend(pend_all[b*32 +: 32])
    );
  end
  assign mask_wr = |bank_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoidle_q <= 1'b0; prot_q <= 1'b0; idle_q <= '0; thr_q <= 8'hFF;
      rst_done_q <= 1'b0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else if (soft_rst) begin
      autoidle_q <= 1'b0; prot_q <= 1'b0; idle_q <= '0; thr_q <= 8'hFF;
      rst_done_q <= 1'b0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else begin
      rst_done_q <= 1'b1;
      if (bus_we) begin
        if (bus_addr == A_CFG)  autoidle_q <= bus_wdata[0];
        if (bus_addr == A_PROT) prot_q     <= bus_wdata[0];
        if (bus_addr == A_IDLE) idle_q     <= bus_wdata[1:0];
        if (bus_addr == A_THR)  thr_q      <= bus_wdata[7:0];
        for (int i = 0; i < N_SRC; i++)
          if (bus_addr == lvl_addr(i)) prio_q[i] <= bus_wdata[7:2];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++) elig[i] = pend_all[i] && prio_ok(prio_q[i], thr_q);
  end

  irqc_arbiter #(.N(N_SRC)) u_arb (
    .elig(elig), .prio(prio_q), .win_valid(win_valid), .win_id(win_id)
  );

  irqc_sorter #(.N(N_SRC), .SORT_CYC(SORT_CYC)) u_sort (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .win_valid(win_valid), .win_id(win_id), .pend(pend_all),
    .mask_wr(mask_wr), .ack(ack_fire), .irq(irq_o), .active_q(sir_q),
    .sort_start(sort_start), .sort_done(sort_done)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:    bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
      A_CFG:    bus_rdata = {31'd0, autoidle_q};
      A_STAT:   bus_rdata = {31'd0, rst_done_q};
      A_ACTIVE: bus_rdata = sir_q;
      A_PROT:   bus_rdata = {31'd0, prot_q};
      A_IDLE:   bus_rdata = {30'd0, idle_q};
      A_THR:    bus_rdata = {24'd0, thr_q};
      default:  bus_rdata = '0;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == bank_addr(A_MASK0, b)) bus_rdata = mask_all[b*32 +: 32];
      if (bus_addr == bank_addr(A_PEND0, b)) bus_rdata = pend_all[b*32 +: 32];
    end
    for (int i = 0; i < N_SRC; i++)
      if (bus_addr == lvl_addr(i)) bus_rdata = {24'd0, prio_q[i], 2'b00};
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned SORT_CYC = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [31:0] sir,
  input logic        sort_start,
  input logic        sort_done,
  input logic        ack,
  input logic        soft_rst,
  input logic        rst_done
);
  logic        busy;
  logic [15:0] scnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; scnt <= '0;
    end else if (soft_rst || sort_done) begin
      busy <= 1'b0; scnt <= '0;
    end else if (sort_start) begin
      busy <= 1'b1; scnt <= '0;
    end else if (busy) begin
      scnt <= scnt + 1'b1;
    end
  end

  AST_SORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sort_done |-> (busy && scnt == 16'(SORT_CYC - 1)));                 // R8
  AST_IRQ_AFTER_SORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sort_done));                                    // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack && !soft_rst) |=> irq);                                 // R11
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> !irq);                                              // R11
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sort_done && !soft_rst) |=> $stable(sir));                         // R11
  AST_SPUR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sir[31:7] != 25'd0) |-> (&sir[31:7]));                              // R9
  AST_SRST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !rst_done);                                             // R2
  AST_SRST_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> rst_done);                                             // R2
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.SORT_CYC(SORT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .sir(sir_q),
  .sort_start(sort_start), .sort_done(sort_done), .ack(ack_fire),
  .soft_rst(soft_rst), .rst_done(rst_done_q)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int NS = 96;
  localparam int SC = 10;
  localparam logic [11:0] T_REV = 12'h000, T_CFG = 12'h010, T_STAT = 12'h014,
    T_ACT = 12'h040, T_CTRL = 12'h048, T_PROT = 12'h04C, T_IDLE = 12'h050,
    T_THR = 12'h068, T_MSK = 12'h084, T_CLR = 12'h088, T_SET = 12'h08C,
    T_PND = 12'h098, T_LVL = 12'h100;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          irq_o;
  int            tests = 0, fails = 0;
  bit            done = 1'b0;
  logic [31:0]   d;
  int            lat;

  prio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #4 clk = ~clk;

  function automatic int fprio(input int i);
    return (i * 37 + 11) % 64;
  endfunction
  function automatic logic [11:0] bk(input logic [11:0] base, input int b);
    return base + 12'(b * 32);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_we = 1'b0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask
  // drive a pattern and count negedges until irq_o is high
  task automatic run_sort(input logic [NS-1:0] p, output int k);
    @(negedge clk); src = p; k = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (irq_o && k == 0) k = n;
    end
  endtask
  task automatic settle();
    @(negedge clk); src = '0;
    wr(T_CTRL, 32'h1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(T_ACT, d); chk("R1 active", d, 32'd0);
    for (int b = 0; b < 3; b++) begin rd(bk(T_MSK, b), d); chk("R1 mask", d, 32'hFFFFFFFF); end
    rd(T_THR, d); chk("R1 thr", d, 32'hFF);
    rd(T_LVL + 12'd28, d); chk("R1 level", d, 32'd0);
    rd(T_CFG, d); chk("R1 cfg", d, 32'd0);
    // R3 revision
    rd(T_REV, d); chk("R3 revision", d, {24'd0, 4'd5, 4'd0});
    // R12 plain storage
    wr(T_THR, 32'h33);  rd(T_THR, d);  chk("R12 thr", d, 32'h33);
    wr(T_IDLE, 32'h2);  rd(T_IDLE, d); chk("R12 idle", d, 32'h2);
    wr(T_PROT, 32'h1);  rd(T_PROT, d); chk("R12 prot", d, 32'h1);
    wr(T_CFG, 32'h1);   rd(T_CFG, d);  chk("R12 autoidle", d, 32'h1);
    wr(T_THR, 32'hFF);
    // R4 mask bank access
    wr(bk(T_CLR, 1), 32'h0000F00F); rd(bk(T_MSK, 1), d); chk("R4 clear", d, ~32'h0000F00F);
    wr(bk(T_SET, 1), 32'h00000003); rd(bk(T_MSK, 1), d); chk("R4 set", d, ~32'h0000F00C);
    wr(bk(T_MSK, 1), 32'hFFFFFFFF); rd(bk(T_MSK, 1), d); chk("R4 direct", d, 32'hFFFFFFFF);
    // R5 pending readback
    wr(bk(T_CLR, 0), 32'h000000F0);
    wr(bk(T_CLR, 2), 32'h00000002);
    @(negedge clk); src = '0; src[7:0] = 8'h3C; src[65] = 1'b1; src[40] = 1'b1;
    rd(bk(T_PND, 0), d); chk("R5 bank0", d, 32'h30);
    rd(bk(T_PND, 1), d); chk("R5 bank1", d, 32'h0);
    rd(bk(T_PND, 2), d); chk("R5 bank2", d, 32'h2);
    settle();
    // R6 single-line sweep, R8 latency
    for (int b = 0; b < 3; b++) wr(bk(T_MSK, b), 32'h0);
    settle();
    for (int i = 0; i < NS; i++) begin
      logic [NS-1:0] p;
      p = '0; p[i] = 1'b1;
      run_sort(p, lat);
      chk("R8 latency", lat, SC + 1);
      rd(T_ACT, d); chk("R6 single line", d, 32'(i));
      settle();
    end
    // R6 priority patterns, ties to lower number
    for (int i = 0; i < NS; i++) wr(T_LVL + 12'(4 * i), 32'(fprio(i) << 2));
    rd(T_LVL + 12'(4 * 77), d); chk("R6 level field", d, 32'(fprio(77) << 2));
    for (int j = 0; j < 8; j++) begin
      logic [NS-1:0] p;
      int best, bid;
      p = '0; best = 99; bid = 0;
      for (int i = 0; i < NS; i++) if (((i * 13 + j * 29) % 7) == 0) p[i] = 1'b1;
      for (int i = 0; i < NS; i++) if (p[i] && fprio(i) < best) begin best = fprio(i); bid = i; end
      run_sort(p, lat);
      rd(T_ACT, d); chk("R6 pattern", d, 32'(bid));
      settle();
    end
    wr(T_LVL + 12'(4 * 12), 32'(1 << 2));
    wr(T_LVL + 12'(4 * 50), 32'(1 << 2));
    begin
      logic [NS-1:0] p;
      p = '0; p[12] = 1'b1; p[50] = 1'b1;
      run_sort(p, lat); rd(T_ACT, d); chk("R6 tie", d, 32'd12);
    end
    settle();
    // R7 threshold (line 20 priority 47)
    wr(T_THR, 32'd47);
    begin
      logic [NS-1:0] p;
      p = '0; p[20] = 1'b1;
      run_sort(p, lat); chk("R7 equal blocks", lat, 0);
      wr(T_THR, 32'd48);
      repeat (SC + 3) @(negedge clk);
      chk("R7 above passes", {31'd0, irq_o}, 32'd1);
      rd(T_ACT, d); chk("R7 winner", d, 32'd20);
    end
    settle();
    wr(T_THR, 32'hFF);
    // R9 candidate drops (line 5)
    @(negedge clk); src = '0; src[5] = 1'b1;
    repeat (3) @(negedge clk); src = '0;
    repeat (SC + 2) @(negedge clk);
    chk("R9 irq", {31'd0, irq_o}, 32'd1);
    rd(T_ACT, d); chk("R9 spurious", d, 32'hFFFFFF85);
    settle();
    // R10 mask write changing winner: line 3 (prio 2) unmasked during window, line 9 prio 24
    wr(T_LVL + 12'd12, 32'(2 << 2));
    wr(bk(T_SET, 0), 32'h00000008);
    @(negedge clk); src = '0; src[3] = 1'b1; src[9] = 1'b1;
    wr(bk(T_CLR, 0), 32'h00000008);
    repeat (SC + 2) @(negedge clk);
    rd(T_ACT, d); chk("R10 changed", d, 32'hFFFFFF89);
    settle();
    // R10 mask write leaving winner: line 41 prio 63
    wr(T_LVL + 12'(4 * 41), 32'(63 << 2));
    wr(bk(T_SET, 1), 32'h00000200);
    @(negedge clk); src = '0; src[9] = 1'b1; src[41] = 1'b1;
    wr(bk(T_CLR, 1), 32'h00000200);
    repeat (SC + 2) @(negedge clk);
    rd(T_ACT, d); chk("R10 unchanged", d, 32'd9);
    // R11 hold until acknowledge (line 0 prio 11 is more urgent)
    @(negedge clk); src = '0; src[0] = 1'b1;
    repeat (15) @(negedge clk);
    chk("R11 held", {31'd0, irq_o}, 32'd1);
    rd(T_ACT, d); chk("R11 no resort", d, 32'd9);
    wr(T_CTRL, 32'h1);
    chk("R11 ack drops", {31'd0, irq_o}, 32'd0);
    repeat (SC + 2) @(negedge clk);
    rd(T_ACT, d); chk("R11 next sort", d, 32'd0);
    // R2 soft reset while request pending
    @(negedge clk); bus_we = 1'b1; bus_addr = T_CFG; bus_wdata = 32'h3;
    @(negedge clk); bus_we = 1'b0; bus_addr = T_STAT; #1;
    chk("R2 busy", bus_rdata, 32'd0);
    @(negedge clk); #1;
    chk("R2 done", bus_rdata, 32'd1);
    chk("R1 soft irq", {31'd0, irq_o}, 32'd0);
    rd(T_CFG, d); chk("R2 cfg bits", d, 32'd0);
    rd(T_ACT, d); chk("R1 soft active", d, 32'd0);
    rd(bk(T_MSK, 0), d); chk("R1 soft mask", d, 32'hFFFFFFFF);
    rd(T_LVL + 12'(4 * 41), d); chk("R1 soft level", d, 32'd0);
    rd(T_THR, d); chk("R1 soft thr", d, 32'hFF);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule